// File: doc/BRIEF.md
# Pixel gamma and bit-alignment formatter

This block sits between a sensor pixel stream and a frame-buffer writer and puts every pixel into one of two storage formats. In compact mode each pixel is used as an index into a loadable byte-wide tone-curve table, and the selected byte comes out in the low half of the output word. In raw mode the table is skipped. The pixel is shifted up so that its most significant sensor bit lands on bit 14. Bit 15 stays zero and the vacated low bits are zeros.

The sensor may deliver 8, 10, 12 or 14 significant bits, capped at the configured pixel width. The active format and depth are captured with the frame-start strobe, so one frame never carries two formats. The tone table is written through its own address/data port between pixels. Both paths have exactly one register stage, so the output strobe is the input strobe delayed by one clock.

Top module: `pix_gamma_fmt`

## Requirements
- R1: In compact mode (`raw_mode` captured as 0) a valid pixel produces `fmt_data = {8'h00, table[index]}`, where index is the pixel masked to the selected depth.
- R2: With `tbl_we` high and `pix_valid` low, `tbl_wdata` is stored at `tbl_addr`. A write attempted while `pix_valid` is high is ignored and the entry keeps its old value.
- R3: In raw mode (`raw_mode` captured as 1) the table is bypassed and bit 15 of `fmt_data` is always 0.
- R4: The depth code `depth_sel` d selects min(8+2*d, PIX_W) bits: 0 gives 8, 1 gives 10, 2 gives 12 and 3 gives 14. In raw mode the masked pixel is shifted left by 15 minus that depth, which puts its top bit on bit 14 and fills the low bits with zeros (12-bit: shift 3, 10-bit: shift 5, 8-bit: shift 7).
- R5: Pixel bits at and above the selected depth have no effect in either mode.
- R6: `fmt_valid` equals `pix_valid` delayed by one clock. While `fmt_valid` is low, `fmt_data` holds its last value.
- R7: `raw_mode` and `depth_sel` are taken only in a cycle with `frame_start` high, and they then apply to that cycle's pixel onward. Changes at any other time have no effect.
- R8: After reset `fmt_valid` and `fmt_data` are 0 and the captured setting is compact mode with depth code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Captures `raw_mode` and `depth_sel` |
| raw_mode | input | 1 | 1 = 16-bit raw, 0 = 8-bit tone mapped |
| depth_sel | input | 2 | Sensor depth code |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | PIX_W | Sensor pixel |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | PIX_W | Table write address |
| tbl_wdata | input | 8 | Table write data |
| fmt_valid | output | 1 | Formatted pixel strobe |
| fmt_data | output | 16 | Formatted pixel |

## Verification
The bench builds the block with the default PIX_W of 12. This gives a 4096-entry table that is fully loaded, and it brings the 8-, 10- and 12-bit alignments within reach. It also covers the depth code 3 case, where 14 bits are clamped to 12. With this width, pixels that carry stray high bits at the smaller depths show that masking works in both modes.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
  // number of significant sensor bits for a depth code, capped at the pixel width
  function automatic int unsigned depth_bits(input logic [1:0] code, input int unsigned pix_w);
    int unsigned b;
    b = 8 + 2 * int'(code);
    return (b > pix_w) ? pix_w : b;
  endfunction

  // keep only the low 'bits' bits of a pixel
  function automatic logic [14:0] mask_pix(input logic [14:0] pix, input int unsigned bits);
    return pix & 15'((32'h1 << bits) - 32'h1);
  endfunction

  // raw word: top sensor bit on bit 14, bit 15 zero, low bits zero
  function automatic logic [15:0] align_raw(input logic [14:0] pix, input int unsigned bits);
    logic [14:0] m;
    m = mask_pix(pix, bits);
    return {1'b0, 15'(m << (15 - bits))};
  endfunction
endpackage

// File: rtl/pgf_cfg_latch.sv
module pgf_cfg_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       raw_in,
  input  logic [1:0] dsel_in,
  output logic       cfg_raw,
  output logic [1:0] cfg_dsel,
  output logic       eff_raw,
  output logic [1:0] eff_dsel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_raw  <= 1'b0;
      cfg_dsel <= 2'd0;
    end else if (frame_start) begin
      cfg_raw  <= raw_in;
      cfg_dsel <= dsel_in;
    end
  end

  // the frame-start cycle already uses the new setting
  always_comb begin
    eff_raw  = frame_start ? raw_in  : cfg_raw;
    eff_dsel = frame_start ? dsel_in : cfg_dsel;
  end
endmodule

// File: rtl/pgf_gamma_ram.sv
module pgf_gamma_ram #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= 8'h00;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgf_raw_stage.sv
module pgf_raw_stage #(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             raw_sel,
  input  logic [1:0]       dsel,
  input  logic [PIX_W-1:0] pix,
  output logic [15:0]      word_q,
  output logic             raw_q,
  output logic [1:0]       dsel_q
);
  import pgf_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= 16'h0000;
      raw_q  <= 1'b0;
      dsel_q <= 2'd0;
    end else if (en) begin
      word_q <= align_raw(15'(pix), depth_bits(dsel, PIX_W));
      raw_q  <= raw_sel;
      dsel_q <= dsel;
    end
  end
endmodule

// File: rtl/pix_gamma_fmt.sv
module pix_gamma_fmt #(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             raw_mode,
  input  logic [1:0]       depth_sel,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             tbl_we,
  input  logic [PIX_W-1:0] tbl_addr,
  input  logic [7:0]       tbl_wdata,
  output logic             fmt_valid,
  output logic [15:0]      fmt_data
);
  import pgf_pkg::*;

  logic             cfg_raw, eff_raw;
  logic [1:0]       cfg_dsel, eff_dsel;
  logic [PIX_W-1:0] lut_index;
  logic             lut_wr;
  logic [7:0]       lut_byte;
  logic [15:0]      raw_word;
  logic             raw_sel_q;
  logic [1:0]       dsel_q;
  logic             valid_q;

  pgf_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .raw_in(raw_mode), .dsel_in(depth_sel),
    .cfg_raw(cfg_raw), .cfg_dsel(cfg_dsel),
    .eff_raw(eff_raw), .eff_dsel(eff_dsel)
  );

  assign lut_index = PIX_W'(mask_pix(15'(pix_data), depth_bits(eff_dsel, PIX_W)));
  assign lut_wr    = tbl_we && !pix_valid;

  pgf_gamma_ram #(.AW(PIX_W)) u_lut (
    .clk(clk), .rst_n(rst_n),
    .we(lut_wr), .waddr(tbl_addr), .wdata(tbl_wdata),
    .re(pix_valid && !eff_raw), .raddr(lut_index), .rdata(lut_byte)
  );

  pgf_raw_stage #(.PIX_W(PIX_W)) u_raw (
    .clk(clk), .rst_n(rst_n), .en(pix_valid),
    .raw_sel(eff_raw), .dsel(eff_dsel), .pix(pix_data),
    .word_q(raw_word), .raw_q(raw_sel_q), .dsel_q(dsel_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= pix_valid;
  end

  assign fmt_valid = valid_q;
  assign fmt_data  = raw_sel_q ? raw_word : {8'h00, lut_byte};
endmodule

// File: rtl/pgf_checker.sv
module pgf_checker #(
  parameter int PIX_W = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_start,
  input logic        pix_valid,
  input logic        fmt_valid,
  input logic [15:0] fmt_data,
  input logic        cfg_raw,
  input logic [1:0]  cfg_dsel,
  input logic        raw_sel_q,
  input logic [1:0]  dsel_q
);
  import pgf_pkg::*;

  function automatic logic [15:0] low_mask(input logic [1:0] d);
    return 16'((32'h1 << (15 - depth_bits(d, PIX_W))) - 32'h1);
  endfunction

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> fmt_valid);
  a_r6_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !fmt_valid);
  a_r6_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable(fmt_data));
  a_r3_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_valid && raw_sel_q) |-> !fmt_data[15]);
  a_r4_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_valid && raw_sel_q) |-> ((fmt_data & low_mask(dsel_q)) == 16'h0000));
  a_r1_upper_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_valid && !raw_sel_q) |-> (fmt_data[15:8] == 8'h00));
  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable({cfg_raw, cfg_dsel}));
endmodule

bind pix_gamma_fmt pgf_checker #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
  .fmt_valid(fmt_valid), .fmt_data(fmt_data), .cfg_raw(cfg_raw),
  .cfg_dsel(cfg_dsel), .raw_sel_q(raw_sel_q), .dsel_q(dsel_q)
);

// File: tb/test_pix_gamma_fmt.sv
module test_pix_gamma_fmt;
  localparam int PIX_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             frame_start = 1'b0, raw_mode = 1'b0, pix_valid = 1'b0, tbl_we = 1'b0;
  logic [1:0]       depth_sel = 2'd0;
  logic [PIX_W-1:0] pix_data = '0, tbl_addr = '0;
  logic [7:0]       tbl_wdata = 8'h00;
  logic             fmt_valid;
  logic [15:0]      fmt_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pix_gamma_fmt #(.PIX_W(PIX_W)) i_pix_gamma_fmt (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .raw_mode(raw_mode),
    .depth_sel(depth_sel), .pix_valid(pix_valid), .pix_data(pix_data),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .fmt_valid(fmt_valid), .fmt_data(fmt_data)
  );

  // bench's own tone curve
  function automatic logic [7:0] curve(input int a);
    return 8'((a * 7 + 3) ^ (a >> 4));
  endfunction

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_entry(input int a, input logic [7:0] v, input logic with_pixel);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = PIX_W'(a); tbl_wdata = v; pix_valid = with_pixel;
    @(negedge clk);
    tbl_we = 1'b0; pix_valid = 1'b0;
  endtask

  // drive one pixel, check result one clock later
  task automatic send(input string req, input logic fs, input logic raw, input logic [1:0] d,
                      input logic [PIX_W-1:0] p, input logic [15:0] exp);
    @(negedge clk);
    frame_start = fs; raw_mode = raw; depth_sel = d; pix_valid = 1'b1; pix_data = p;
    @(posedge clk); #1;
    check(req, {fmt_valid, fmt_data}, {1'b1, exp});
    @(negedge clk);
    frame_start = 1'b0; pix_valid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check("R8 reset outputs", {fmt_valid, fmt_data}, 17'h0);
  endtask

  task automatic t_load;
    for (int a = 0; a < (1 << PIX_W); a++) write_entry(a, curve(a), 1'b0);
  endtask

  task automatic t_reset_cfg;
    // no frame_start yet: compact mode, 8 bits -> index 0x34
    send("R8 default compact depth0", 1'b0, 1'b1, 2'd2, 12'hF34, {8'h00, curve('h34)});
  endtask

  task automatic t_gamma;
    send("R1 gamma 12b", 1'b1, 1'b0, 2'd2, 12'hABC, {8'h00, curve('hABC)});
    send("R1 gamma zero", 1'b0, 1'b0, 2'd2, 12'h000, {8'h00, curve(0)});
    send("R1 gamma full", 1'b0, 1'b0, 2'd2, 12'hFFF, {8'h00, curve('hFFF)});
    send("R5 gamma 10b mask", 1'b1, 1'b0, 2'd1, 12'hC12, {8'h00, curve('h012)});
    send("R5 gamma 8b mask", 1'b1, 1'b0, 2'd0, 12'hF5A, {8'h00, curve('h05A)});
  endtask

  task automatic t_raw;
    send("R4 raw 12b shift3", 1'b1, 1'b1, 2'd2, 12'hFFF, 16'h7FF8);
    send("R3 raw 12b", 1'b0, 1'b1, 2'd2, 12'h801, 16'h4008);
    send("R4 raw 10b shift5", 1'b1, 1'b1, 2'd1, 12'h3FF, 16'h7FE0);
    send("R5 raw 10b mask", 1'b0, 1'b1, 2'd1, 12'hC01, 16'h0020);
    send("R4 raw 8b shift7", 1'b1, 1'b1, 2'd0, 12'h0AB, 16'h5580);
    send("R4 raw code3 clamp", 1'b1, 1'b1, 2'd3, 12'hABC, 16'h55E0);
  endtask

  task automatic t_cfg;
    send("R7 frame raw", 1'b1, 1'b1, 2'd2, 12'h123, 16'h0918);
    send("R7 mid-frame change ignored", 1'b0, 1'b0, 2'd0, 12'h123, 16'h0918);
    send("R7 new frame takes effect", 1'b1, 1'b0, 2'd2, 12'h123, {8'h00, curve('h123)});
  endtask

  task automatic t_write_block;
    write_entry('h2A5, 8'hEE, 1'b1);
    send("R2 blocked write", 1'b1, 1'b0, 2'd2, 12'h2A5, {8'h00, curve('h2A5)});
    write_entry('h2A5, 8'h5C, 1'b0);
    send("R2 idle write", 1'b0, 1'b0, 2'd2, 12'h2A5, 16'h005C);
  endtask

  task automatic t_hold;
    send("R6 prime", 1'b1, 1'b1, 2'd2, 12'h0F0, 16'h0780);
    @(negedge clk); pix_data = 12'hFFF; raw_mode = 1'b0;
    @(posedge clk); #1;
    check("R6 idle hold", {fmt_valid, fmt_data}, {1'b0, 16'h0780});
    @(posedge clk); #1;
    check("R6 idle hold 2", {fmt_valid, fmt_data}, {1'b0, 16'h0780});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_load;
    t_reset_cfg;
    t_gamma;
    t_raw;
    t_cfg;
    t_write_block;
    t_hold;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule